// File: doc/BRIEF.md
# DDR Bank Precharge Timing Guard

This block sits in a memory controller next to the command scheduler and tracks the timing state of one DRAM bank. It watches the command stream sent to that bank (activate, read, read with automatic precharge, precharge). On every clock it reports whether a precharge may be issued now, whether a precharge issued now would leave any read burst in flight intact, and whether a new activate is legal. The scheduler uses these flags to pick its next command. One copy of the block is placed per bank.

The minimum row-open time and the precharge recovery time are given in picoseconds together with the clock period. Both are turned into whole clock counts at elaboration by ceiling division. Commands only issue on rising edges, so a count is always an integer. A read burst of BURST_LEN beats moves two beats per clock, so its last data leaves CAS_LAT + BURST_LEN/2 clocks after the read. The earliest precharge that does not cut the burst falls CAS_LAT clocks before that end. That point is BURST_LEN/2 clocks after the read, whatever the CAS latency.

A read with automatic precharge starts an internal precharge at that same non-cutting point. If the minimum row-open time has not yet passed, the internal precharge waits for it. The block pulses an output on the cycle the internal precharge starts, and recovery time is counted from that cycle.

Top module: `ddr_bank_guard`

## Requirements
- R1: After reset the bank is closed: act_ok_o is 1, and pre_ok_o, pre_clean_o, ap_start_o and act_viol_o are 0.
- R2: The row-open time in clocks is ceil(T_RAS_PS / T_CK_PS), and the recovery time in clocks is ceil(T_RP_PS / T_CK_PS). With the default parameters these are 10 and 4.
- R3: After an accepted activate in cycle a, pre_ok_o is 0 up to cycle a + RAS clocks, and 1 from that cycle on while the bank is open and no automatic precharge is pending.
- R4: After an accepted read or read-with-autoprecharge in cycle r, pre_clean_o is 0 before cycle r + BURST_LEN/2. From then on it equals pre_ok_o.
- R5: A precharge issued while pre_ok_o is 1 and the burst point is not reached is accepted, and pre_cut_o is 1 in that same cycle. pre_cut_o is 0 in every other case.
- R6: After a precharge accepted in cycle p, act_ok_o is 0 until cycle p + RP clocks and 1 from that cycle on. While the bank is open, act_ok_o is 0.
- R7: After a read-with-autoprecharge, ap_start_o pulses for one cycle, at the later of the burst point and the row-open point. act_ok_o rises exactly RP clocks after that pulse.
- R8: While an automatic precharge is pending, pre_ok_o is 0. Precharge and read commands have no effect: the pulse time of R7 does not change.
- R9: An activate issued while act_ok_o is 0 is ignored and sets act_viol_o. act_viol_o stays set until reset.
- R10: A precharge issued while pre_ok_o is 0 on an open bank is ignored: the bank stays open and act_ok_o stays 0.
- R11: Command codes on cmd_i: 0 no operation, 1 activate, 2 read, 3 read with autoprecharge, 4 precharge. Codes 5 to 7 act as no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are taken on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Command issued to this bank in this cycle |
| pre_ok_o | output | 1 | A precharge would be accepted this cycle |
| pre_clean_o | output | 1 | A precharge now is accepted and cuts no read burst |
| pre_cut_o | output | 1 | The precharge on cmd_i this cycle cuts a read burst short |
| act_ok_o | output | 1 | An activate would be accepted this cycle |
| ap_start_o | output | 1 | Internal automatic precharge starts this cycle |
| act_viol_o | output | 1 | Sticky: an activate was issued while not allowed |

## Verification
Some properties hold on every cycle, and the assertions check those. A fresh activate blocks precharge on the next cycle. An accepted precharge or an internal precharge start blocks activate on the next cycle. The clean flag never rises without the allowed flag. A cut and a clean precharge never coincide. The internal-start pulse lasts one cycle and never coincides with precharge being allowed. The violation flag never drops. Only the bench's timed scenarios can show the exact cycle counts. These are the ceiling-rounded row-open and recovery windows, and the burst point at each read offset. They also include the later-of-two start of the automatic precharge, and the fact that ignored precharges and reads leave that timing unchanged.

// File: rtl/dg_pkg.sv
package dg_pkg;

   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_ACT = 3'd1,
      CMD_RD  = 3'd2,
      CMD_RDA = 3'd3,
      CMD_PRE = 3'd4
   } dg_cmd_e;

   typedef enum logic [1:0] {
      BK_IDLE  = 2'd0,
      BK_OPEN  = 2'd1,
      BK_PRECH = 2'd2
   } dg_bank_e;

   // whole clocks needed to cover a picosecond interval
   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/dg_countdown.sv
module dg_countdown #(
   parameter int unsigned MAX_VAL = 1,
   localparam int unsigned W = (MAX_VAL == 0) ? 1 : $clog2(MAX_VAL + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   generate
      if (MAX_VAL == 0) begin : g_const
         // a one-clock window needs no storage
         logic unused_inputs;
         assign unused_inputs = &{1'b0, clk, rst_n, load, load_val};
         assign zero = 1'b1;
      end else begin : g_cnt
         logic [W-1:0] cnt;

         always_ff @(posedge clk) begin
            if (!rst_n)          cnt <= '0;
            else if (load)       cnt <= load_val;
            else if (cnt != '0)  cnt <= cnt - 1'b1;
         end

         assign zero = (cnt == '0);

         p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (32'(cnt) <= MAX_VAL));
         p_zero_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (zero && !load) |=> zero);
      end
   endgenerate

endmodule

// File: rtl/dg_bank_fsm.sv
module dg_bank_fsm
   import dg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] cmd,
   input  logic       ras_done,
   input  logic       rd_done,
   input  logic       rp_done,
   output logic       pre_ok,
   output logic       pre_clean,
   output logic       pre_cut,
   output logic       act_ok,
   output logic       ap_start,
   output logic       act_viol,
   output logic       ld_ras,
   output logic       ld_rd,
   output logic       rd_burst,
   output logic       ld_rp
);

   dg_bank_e state;
   logic     ap_pend;
   logic     is_act, is_rd, is_rda, is_pre;
   logic     act_go, rd_go, pre_go;

   assign is_act = (cmd == CMD_ACT);
   assign is_rd  = (cmd == CMD_RD);
   assign is_rda = (cmd == CMD_RDA);
   assign is_pre = (cmd == CMD_PRE);

   assign pre_ok    = (state == BK_OPEN) && !ap_pend && ras_done;
   assign pre_clean = pre_ok && rd_done;
   assign pre_cut   = is_pre && pre_ok && !rd_done;
   assign ap_start  = (state == BK_OPEN) && ap_pend && ras_done && rd_done;
   assign act_ok    = (state == BK_IDLE) || ((state == BK_PRECH) && rp_done);

   assign act_go = is_act && act_ok;
   assign rd_go  = (is_rd || is_rda) && (state == BK_OPEN) && !ap_pend;
   assign pre_go = is_pre && pre_ok;

   assign ld_ras   = act_go;
   assign ld_rd    = act_go || rd_go;
   assign rd_burst = rd_go;
   assign ld_rp    = pre_go || ap_start;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= BK_IDLE;
         ap_pend <= 1'b0;
      end else begin
         if (ap_start) begin
            state   <= BK_PRECH;
            ap_pend <= 1'b0;
         end else if (pre_go) begin
            state <= BK_PRECH;
         end else if (act_go) begin
            state <= BK_OPEN;
         end else if ((state == BK_PRECH) && rp_done) begin
            state <= BK_IDLE;
         end
         if (rd_go && is_rda) ap_pend <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                 act_viol <= 1'b0;
      else if (is_act && !act_ok) act_viol <= 1'b1;
   end

   p_open_no_act_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == BK_OPEN) |-> !act_ok);
   p_pend_no_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ap_pend && !ap_start) |=> $stable(ap_pend) || ap_start);

endmodule

// File: rtl/ddr_bank_guard.sv
module ddr_bank_guard
   import dg_pkg::*;
#(
   parameter int T_CK_PS   = 4000,
   parameter int T_RAS_PS  = 40000,
   parameter int T_RP_PS   = 15000,
   parameter int CAS_LAT   = 2,
   parameter int BURST_LEN = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] cmd_i,
   output logic       pre_ok_o,
   output logic       pre_clean_o,
   output logic       pre_cut_o,
   output logic       act_ok_o,
   output logic       ap_start_o,
   output logic       act_viol_o
);

   localparam int RAS_CYC   = ceil_div(T_RAS_PS, T_CK_PS);
   localparam int RP_CYC    = ceil_div(T_RP_PS, T_CK_PS);
   // last beat leaves CAS_LAT + BURST_LEN/2 after the read; clean point is CAS_LAT earlier
   localparam int BURST_END = CAS_LAT + BURST_LEN / 2;
   localparam int CLEAN_OFS = BURST_END - CAS_LAT;
   localparam int RAS_MAX   = RAS_CYC - 1;
   localparam int RP_MAX    = RP_CYC - 1;
   localparam int RD_MAX    = CLEAN_OFS - 1;
   localparam int RAS_W     = (RAS_MAX == 0) ? 1 : $clog2(RAS_MAX + 1);
   localparam int RP_W      = (RP_MAX == 0) ? 1 : $clog2(RP_MAX + 1);
   localparam int RD_W      = (RD_MAX == 0) ? 1 : $clog2(RD_MAX + 1);

   generate
      if (T_CK_PS < 1) begin : g_bad_ck
         $error("clock period must be positive");
      end
      if ((T_RAS_PS < 1) || (T_RP_PS < 1)) begin : g_bad_time
         $error("timing intervals must be positive");
      end
      if (CAS_LAT < 1) begin : g_bad_cl
         $error("CAS latency must be at least one clock");
      end
      if ((BURST_LEN < 2) || (BURST_LEN % 2 != 0)) begin : g_bad_bl
         $error("burst length must be even and at least two");
      end
   endgenerate

   logic            ras_done, rd_done, rp_done;
   logic            ld_ras, ld_rd, rd_burst, ld_rp;
   logic [RD_W-1:0] rd_val;

   dg_bank_fsm i_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd       (cmd_i),
      .ras_done  (ras_done),
      .rd_done   (rd_done),
      .rp_done   (rp_done),
      .pre_ok    (pre_ok_o),
      .pre_clean (pre_clean_o),
      .pre_cut   (pre_cut_o),
      .act_ok    (act_ok_o),
      .ap_start  (ap_start_o),
      .act_viol  (act_viol_o),
      .ld_ras    (ld_ras),
      .ld_rd     (ld_rd),
      .rd_burst  (rd_burst),
      .ld_rp     (ld_rp)
   );

   dg_countdown #(.MAX_VAL(RAS_MAX)) i_ras_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld_ras),
      .load_val (RAS_W'(RAS_MAX)),
      .zero     (ras_done)
   );

   // activate clears the burst window, a read opens it
   assign rd_val = rd_burst ? RD_W'(RD_MAX) : '0;

   dg_countdown #(.MAX_VAL(RD_MAX)) i_rd_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld_rd),
      .load_val (rd_val),
      .zero     (rd_done)
   );

   dg_countdown #(.MAX_VAL(RP_MAX)) i_rp_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld_rp),
      .load_val (RP_W'(RP_MAX)),
      .zero     (rp_done)
   );

   p_ras_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((RAS_CYC > 1) && (cmd_i == CMD_ACT) && act_ok_o) |=> !pre_ok_o);
   p_clean_subset_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pre_clean_o |-> pre_ok_o);
   p_cut_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pre_cut_o |-> !pre_clean_o);
   p_rp_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((RP_CYC > 1) && (cmd_i == CMD_PRE) && pre_ok_o) |=> !act_ok_o);
   p_ap_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ap_start_o |=> !ap_start_o);
   p_ap_rp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((RP_CYC > 1) && ap_start_o) |=> !act_ok_o);
   p_ap_blocks_pre_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ap_start_o |-> !pre_ok_o);
   p_viol_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      act_viol_o |=> act_viol_o);

endmodule

// File: tb/test_ddr_bank_guard.sv
`timescale 1ns/1ps
module test_ddr_bank_guard;

   localparam int TCK = 4000, TRAS = 40000, TRP = 15000, CL = 2, BL = 8;
   localparam int RAS_EXP = (TRAS + TCK - 1) / TCK;
   localparam int RP_EXP  = (TRP + TCK - 1) / TCK;
   localparam int HALF    = BL / 2;
   localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2,
                          C_RDA = 3'd3, C_PRE = 3'd4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] cmd = C_NOP;
   logic       pre_ok, pre_clean, pre_cut, act_ok, ap_start, act_viol;

   always #2 clk = ~clk;

   ddr_bank_guard #(.T_CK_PS(TCK), .T_RAS_PS(TRAS), .T_RP_PS(TRP),
                    .CAS_LAT(CL), .BURST_LEN(BL)) i_ddr_bank_guard (
      .clk(clk), .rst_n(rst_n), .cmd_i(cmd),
      .pre_ok_o(pre_ok), .pre_clean_o(pre_clean), .pre_cut_o(pre_cut),
      .act_ok_o(act_ok), .ap_start_o(ap_start), .act_viol_o(act_viol));

   int  n_chk = 0, n_fail = 0;
   bit  done = 1'b0;
   int  cyc = 0, t_act = -100, t_clean = 0, t_rp_ok = 0;
   bit  m_open = 0, m_ap = 0, m_viol = 0, ign8 = 0, ign10 = 0;
   logic obs_pre_ok, obs_act_ok;

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s cycle %0d: got %b expected %b", tag, cyc, act, exp);
      end
   endtask

   task automatic chk_int(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step(input logic [2:0] c);
      logic ras_ok, clean_ok, e_pre, e_clean, e_ap, e_act, e_cut;
      @(negedge clk);
      cmd = c;
      #1;
      ras_ok   = (cyc >= t_act + RAS_EXP);
      clean_ok = (cyc >= t_clean);
      e_pre    = m_open && !m_ap && ras_ok;
      e_clean  = e_pre && clean_ok;
      e_ap     = m_open && m_ap && ras_ok && clean_ok;
      e_act    = !m_open && (cyc >= t_rp_ok);
      e_cut    = (c == C_PRE) && e_pre && !clean_ok;
      if (ign8)  chk("R8 ignored precharge", pre_ok, 1'b0);
      if (ign10) chk("R10 ignored precharge", act_ok, 1'b0);
      ign8 = 0; ign10 = 0;
      chk("R3 pre_ok", pre_ok, e_pre);
      chk("R4 pre_clean", pre_clean, e_clean);
      chk("R5 pre_cut", pre_cut, e_cut);
      chk("R6 act_ok", act_ok, e_act);
      chk("R7 ap_start", ap_start, e_ap);
      chk("R9 act_viol", act_viol, m_viol);
      obs_pre_ok = pre_ok;
      obs_act_ok = act_ok;
      if ((c == C_ACT) && !e_act) m_viol = 1;
      if ((c == C_PRE) && m_open && !e_pre) begin
         if (m_ap) ign8 = 1; else ign10 = 1;
      end
      if (e_ap) begin
         m_open = 0; m_ap = 0; t_rp_ok = cyc + RP_EXP;
      end else if ((c == C_PRE) && e_pre) begin
         m_open = 0; t_rp_ok = cyc + RP_EXP;
      end else if ((c == C_ACT) && e_act) begin
         m_open = 1; t_act = cyc; t_clean = cyc;
      end else if (((c == C_RD) || (c == C_RDA)) && m_open && !m_ap) begin
         t_clean = cyc + HALF;
         if (c == C_RDA) m_ap = 1;
      end
      @(posedge clk);
      cyc++;
   endtask

   task automatic close_bank();
      for (int i = 0; i < 40 && m_open; i++) step(m_ap ? C_NOP : C_PRE);
      for (int i = 0; i < 40 && !(cyc >= t_rp_ok); i++) step(C_NOP);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 act_ok", act_ok, 1'b1);
      chk("R1 pre_ok", pre_ok, 1'b0);
      chk("R1 pre_clean", pre_clean, 1'b0);
      chk("R1 ap_start", ap_start, 1'b0);
      chk("R1 act_viol", act_viol, 1'b0);
      @(posedge clk);

      // R2 window lengths measured at the ports
      begin
         int n = 0;
         step(C_ACT);
         do begin step(C_NOP); n++; end while (!obs_pre_ok && n < 64);
         chk_int("R2 row-open clocks", n, RAS_EXP);
         step(C_PRE);
         n = 0;
         do begin step(C_NOP); n++; end while (!obs_act_ok && n < 64);
         chk_int("R2 recovery clocks", n, RP_EXP);
      end

      // R11 unused codes behave as no operation
      step(3'd5); step(3'd6); step(3'd7);

      // plain reads: sweep read offset and precharge offset (R3 R4 R5 R10)
      for (int d = 0; d < 12; d++) begin
         for (int k = 0; k < 7; k++) begin
            step(C_ACT);
            repeat (d) step(C_NOP);
            step(C_RD);
            repeat (k) step(C_NOP);
            step(C_PRE);
            close_bank();
         end
      end

      // autoprecharge reads with ignored commands while pending (R7 R8)
      for (int d = 0; d < 13; d++) begin
         for (int j = 0; j < 3; j++) begin
            step(C_ACT);
            repeat (d) step(C_NOP);
            step(C_RDA);
            if (j == 1) step(C_PRE);
            if (j == 2) step(C_RD);
            close_bank();
            step(C_NOP);
         end
      end

      // R9 activate on an open bank, then flag stays set
      step(C_ACT);
      step(C_ACT);
      close_bank();
      step(C_ACT);
      close_bank();
      repeat (3) step(C_NOP);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule